// File: doc/BRIEF.md
# Stereo I2S to Sign-Magnitude Ladder Shifter

The block takes a stereo PCM stream arriving on an I2S link and drives two external chains of serial-in, parallel-out latching shift registers, one chain per channel. The chains feed a resistor-ladder converter. The three I2S wires are resynchronised into the system clock domain. Each captured two's-complement sample becomes a sign bit plus a magnitude. That word is spread across the register chain so that the top output of every register chip receives a zero.

Both channels shift out together on separate data lines that share one shift clock. After the last shift, a single storage-clock pulse updates every ladder input at once. The active-low output enable stays inactive until the first complete stereo pair has reached the register outputs. The system clock must be fast enough to finish one full chain transfer within a sample period.

Top module: `i2s_ladder_drv`

## Requirements
- R1: Word select low marks the left word and high marks the right word. The sample MSB is sampled on the first bit-clock rising edge after the word-select change, and SAMPLE_W bits are taken MSB-first. Any further bits in a longer slot are ignored.
- R2: When a slot is exactly SAMPLE_W bit clocks long, the LSB arrives in the bit period in which word select changes, and the word is still captured in full.
- R3: A non-negative sample gives sign 0 and magnitude equal to its value. A negative sample gives sign 1 and magnitude equal to its absolute value, using SAMPLE_W-1 magnitude bits.
- R4: The most negative input code (sign bit 1, all other bits 0) gives sign 1 and a magnitude of all ones.
- R5: Each chip takes DATA_PER_CHIP+1 consecutive shift positions. The first position shifted for each chip is a zero pad, which lands on that chip's unused top output. It is followed by DATA_PER_CHIP data positions. Data positions are filled in shift order with the sign bit, then the magnitude MSB-first. Data positions beyond SAMPLE_W hold 0.
- R6: Serial data changes only while the shift clock is low. Exactly CHIPS*(DATA_PER_CHIP+1) shift-clock rising edges occur per storage update.
- R7: The storage clock pulses high only after the final shift-clock edge of a transfer, and never while the shift clock is high. The same pulse latches both channels.
- R8: The active-low output enable is high from reset until the first storage pulse. It goes low at the end of that pulse and never returns high.
- R9: A stereo pair is transferred only after a left word and then a right word are both complete. A right word captured with no left word before it produces no transfer.
- R10: Under reset the shift clock, storage clock and both data lines are low, and the output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | I2S bit clock |
| ws_i | input | 1 | I2S word select (0 left, 1 right) |
| sd_i | input | 1 | I2S serial data |
| sclk_o | output | 1 | Shift clock to both register chains |
| rclk_o | output | 1 | Storage clock to both register chains |
| oe_no | output | 1 | Output enable, active low |
| sdo_l_o | output | 1 | Serial data, left chain |
| sdo_r_o | output | 1 | Serial data, right chain |

## Verification
The bench builds the block with SAMPLE_W=6, CHIPS=3, DATA_PER_CHIP=3 and HALF_CYC=1. This gives a 12-position chain with 9 data positions, so every one of the 64 input codes can be driven on both channels, including the clamped most-negative code. The codes are swept twice: once with 8-bit slots that carry unused trailing bits, and once with slots exactly as wide as the sample, where each LSB shares a bit period with the word-select change. The chain is small enough that the bench models both external register chains bit by bit and compares every latched pattern against a layout it computes arithmetically.

// File: rtl/ladder_drv_pkg.sv
package ladder_drv_pkg;
  localparam int NCH = 2;
  localparam int CH_L = 0;
  localparam int CH_R = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_SETTLE,
    ST_STROBE
  } shift_st_e;
endpackage

// File: rtl/ladder_i2s_rx.sv
module ladder_i2s_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic                pair_vld_o,
  output logic [SAMPLE_W-1:0] word_l_o,
  output logic [SAMPLE_W-1:0] word_r_o
);
  localparam int CW = $clog2(SAMPLE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(SAMPLE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(SAMPLE_W - 1);

  // stage 0 is the input side; bit order {bclk, ws, sd}
  logic [2:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '0;
    else         sync_q[0] <= {bclk_i, ws_i, sd_i};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  logic bclk_s, ws_s, sd_s;
  assign {bclk_s, ws_s, sd_s} = sync_q[SYNC_STAGES-1];

  logic                bclk_d_q, ws_q, ch_q, l_ok_q;
  logic [CW-1:0]       cnt_q;
  logic [SAMPLE_W-1:0] sh_q, left_q;
  logic                bit_rise;
  logic [SAMPLE_W-1:0] sh_nxt;

  assign bit_rise = bclk_s & ~bclk_d_q;
  assign sh_nxt   = {sh_q[SAMPLE_W-2:0], sd_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d_q   <= 1'b0;
      ws_q       <= 1'b0;
      ch_q       <= 1'b0;
      l_ok_q     <= 1'b0;
      cnt_q      <= CNT_FULL;
      sh_q       <= '0;
      left_q     <= '0;
      word_l_o   <= '0;
      word_r_o   <= '0;
      pair_vld_o <= 1'b0;
    end else begin
      bclk_d_q   <= bclk_s;
      pair_vld_o <= 1'b0;
      if (bit_rise) begin
        // the bit sampled on a word-select change still belongs to the old word
        if (cnt_q < CNT_FULL) begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            if (!ch_q) begin
              left_q <= sh_nxt;
              l_ok_q <= 1'b1;
            end else if (l_ok_q) begin
              word_l_o   <= left_q;
              word_r_o   <= sh_nxt;
              pair_vld_o <= 1'b1;
              l_ok_q     <= 1'b0;
            end
          end
        end
        if (ws_s != ws_q) begin
          ws_q  <= ws_s;
          ch_q  <= ws_s;
          cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ladder_framer.sv
module ladder_framer #(
  parameter int SAMPLE_W      = 24,
  parameter int CHIPS         = 8,
  parameter int DATA_PER_CHIP = 6
) (
  input  logic [SAMPLE_W-1:0]                    pcm_i,
  output logic [CHIPS*(DATA_PER_CHIP+1)-1:0]     frame_o
);
  localparam int GRP = DATA_PER_CHIP + 1;
  localparam int LEN = CHIPS * GRP;
  localparam int MW  = SAMPLE_W - 1;

  logic                neg;
  logic [SAMPLE_W-1:0] negx;
  logic [MW-1:0]       mag;
  logic [SAMPLE_W-1:0] smw;

  always_comb begin
    neg  = pcm_i[SAMPLE_W-1];
    negx = '0 - pcm_i;
    if (!neg)                   mag = pcm_i[MW-1:0];
    else if (pcm_i[MW-1:0] == '0) mag = '1;  // clamp most negative code
    else                        mag = negx[MW-1:0];
    smw = {neg, mag};
  end

  // frame_o[LEN-1] leaves first; position 0 of each chip group is the pad
  always_comb begin
    frame_o = '0;
    for (int g = 0; g < CHIPS; g++) begin
      for (int j = 1; j < GRP; j++) begin
        int idx;
        idx = SAMPLE_W - g * DATA_PER_CHIP - j;
        if (idx >= 0) frame_o[LEN-1-(g*GRP+j)] = smw[idx];
      end
    end
  end
endmodule

// File: rtl/ladder_shifter.sv
module ladder_shifter
  import ladder_drv_pkg::*;
#(
  parameter int LEN      = 56,
  parameter int HALF_CYC = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [LEN-1:0] frame_i [NCH],
  output logic           sclk_o,
  output logic           rclk_o,
  output logic           oe_no,
  output logic [NCH-1:0] sdo_o
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int BW = $clog2(LEN);
  localparam logic [TW-1:0] T_LAST = TW'(HALF_CYC - 1);
  localparam logic [BW-1:0] B_LAST = BW'(LEN - 1);

  shift_st_e     st_q;
  logic [TW-1:0] tmr_q;
  logic [BW-1:0] bit_q;
  logic          tmr_done, do_load, do_shift;

  assign tmr_done = (tmr_q == T_LAST);
  assign do_load  = (st_q == ST_IDLE) && start_i;
  assign do_shift = (st_q == ST_HIGH) && tmr_done && (bit_q != B_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      bit_q  <= '0;
      sclk_o <= 1'b0;
      rclk_o <= 1'b0;
      oe_no  <= 1'b1;
    end else begin
      tmr_q <= tmr_done ? '0 : tmr_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (start_i) begin
            bit_q <= '0;
            st_q  <= ST_LOW;
          end
        end
        ST_LOW: if (tmr_done) begin
          sclk_o <= 1'b1;
          st_q   <= ST_HIGH;
        end
        ST_HIGH: if (tmr_done) begin
          sclk_o <= 1'b0;
          if (bit_q == B_LAST) st_q <= ST_SETTLE;
          else begin
            bit_q <= bit_q + 1'b1;
            st_q  <= ST_LOW;
          end
        end
        ST_SETTLE: if (tmr_done) begin
          rclk_o <= 1'b1;
          st_q   <= ST_STROBE;
        end
        ST_STROBE: if (tmr_done) begin
          rclk_o <= 1'b0;
          oe_no  <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [LEN-1:0] frm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       frm_q <= '0;
      else if (do_load)  frm_q <= frame_i[c];
      else if (do_shift) frm_q <= {frm_q[LEN-2:0], 1'b0};
    end
    assign sdo_o[c] = frm_q[LEN-1];
  end
endmodule

// File: rtl/i2s_ladder_drv.sv
module i2s_ladder_drv
  import ladder_drv_pkg::*;
#(
  parameter int SAMPLE_W      = 24,
  parameter int CHIPS         = 8,
  parameter int DATA_PER_CHIP = 6,
  parameter int HALF_CYC      = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic sclk_o,
  output logic rclk_o,
  output logic oe_no,
  output logic sdo_l_o,
  output logic sdo_r_o
);
  localparam int SHIFT_LEN = CHIPS * (DATA_PER_CHIP + 1);

  logic                 pair_vld;
  logic [SAMPLE_W-1:0]  words [NCH];
  logic [SHIFT_LEN-1:0] frames [NCH];
  logic [NCH-1:0]       sdo;

  ladder_i2s_rx #(
    .SAMPLE_W   (SAMPLE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bclk_i    (bclk_i),
    .ws_i      (ws_i),
    .sd_i      (sd_i),
    .pair_vld_o(pair_vld),
    .word_l_o  (words[CH_L]),
    .word_r_o  (words[CH_R])
  );

  for (genvar c = 0; c < NCH; c++) begin : g_frm
    ladder_framer #(
      .SAMPLE_W     (SAMPLE_W),
      .CHIPS        (CHIPS),
      .DATA_PER_CHIP(DATA_PER_CHIP)
    ) u_frm (
      .pcm_i  (words[c]),
      .frame_o(frames[c])
    );
  end

  ladder_shifter #(
    .LEN     (SHIFT_LEN),
    .HALF_CYC(HALF_CYC)
  ) u_shf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(pair_vld),
    .frame_i(frames),
    .sclk_o (sclk_o),
    .rclk_o (rclk_o),
    .oe_no  (oe_no),
    .sdo_o  (sdo)
  );

  assign sdo_l_o = sdo[CH_L];
  assign sdo_r_o = sdo[CH_R];
endmodule

// File: rtl/ladder_drv_chk.sv
module ladder_drv_chk #(
  parameter int LEN = 56
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic rclk_o,
  input logic oe_no,
  input logic sdo_l_o,
  input logic sdo_r_o
);
  localparam int CW = $clog2(LEN + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic          sclk_d, rclk_d, seen_q;
  logic [CW-1:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rclk_d   <= 1'b0;
      seen_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      rclk_d <= rclk_o;
      if (rclk_o) seen_q <= 1'b1;
      if (rclk_o && !rclk_d)                          rise_cnt <= '0;
      else if (sclk_o && !sclk_d && rise_cnt != CMAX) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R6
  sdo_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ($stable(sdo_l_o) && $stable(sdo_r_o)));

  // R6
  shift_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rclk_o && !rclk_d) |-> (rise_cnt == CW'(LEN)));

  // R7
  clk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_o && rclk_o));

  // R8
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> oe_no);

  // R8
  oe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |=> !oe_no);
endmodule

bind i2s_ladder_drv ladder_drv_chk #(.LEN(SHIFT_LEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sclk_o (sclk_o),
  .rclk_o (rclk_o),
  .oe_no  (oe_no),
  .sdo_l_o(sdo_l_o),
  .sdo_r_o(sdo_r_o)
);

// File: tb/sim_i2s_ladder_drv.sv
`timescale 1ns/1ps
module sim_i2s_ladder_drv;
  localparam int W   = 6;
  localparam int CH  = 3;
  localparam int DPC = 3;
  localparam int LEN = CH * (DPC + 1);
  localparam int NF  = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, ws = 1'b0, sd = 1'b0;
  logic sclk, rclk, oe_n, sdo_l, sdo_r;

  always #2.5 clk = ~clk;

  i2s_ladder_drv #(
    .SAMPLE_W(W), .CHIPS(CH), .DATA_PER_CHIP(DPC), .HALF_CYC(1), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .ws_i(ws), .sd_i(sd),
    .sclk_o(sclk), .rclk_o(rclk), .oe_no(oe_n), .sdo_l_o(sdo_l), .sdo_r_o(sdo_r)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // external register chain model
  logic [LEN-1:0] chain_l = '0, chain_r = '0;
  int nsh = 0, nl = 0;
  logic [LEN-1:0] lat_l [NF+4];
  logic [LEN-1:0] lat_r [NF+4];
  int             sh_at [NF+4];
  logic           oe_at [NF+4];

  always @(posedge sclk) begin
    chain_l <= {chain_l[LEN-2:0], sdo_l};
    chain_r <= {chain_r[LEN-2:0], sdo_r};
    nsh     <= nsh + 1;
  end

  always @(posedge rclk) begin
    if (nl < NF + 4) begin
      lat_l[nl] <= chain_l;
      lat_r[nl] <= chain_r;
      sh_at[nl] <= nsh;
      oe_at[nl] <= oe_n;
    end
    nl <= nl + 1;
  end

  // expected chain contents for a code: pad-first groups, sign then magnitude
  function automatic logic [LEN-1:0] exp_chain(input int code);
    int sgn, mag, smw;
    logic [LEN-1:0] e;
    sgn = (code >= (1 << (W-1))) ? 1 : 0;
    mag = sgn ? ((1 << W) - code) : code;
    if (mag > (1 << (W-1)) - 1) mag = (1 << (W-1)) - 1;
    smw = sgn * (1 << (W-1)) + mag;
    e = '0;
    for (int p = 0; p < LEN; p++) begin
      int g, j, d;
      g = p / (DPC + 1);
      j = p % (DPC + 1);
      if (j != 0) begin
        d = g * DPC + j - 1;
        if (d < W) e[LEN-1-p] = ((smw >> (W-1-d)) & 1) != 0;
      end
    end
    return e;
  endfunction

  int carry = 0;
  int exp_l [NF];
  int exp_r [NF];

  task automatic send_word(input logic w, input int v, input int slot);
    for (int k = 0; k < slot; k++) begin
      int b;
      b = k - 1;
      ws = w;
      if (k == 0)     sd = carry[0];
      else if (b < W) sd = ((v >> (W-1-b)) & 1) != 0;
      else            sd = 1'b0;
      bclk = 1'b0;
      #20;
      bclk = 1'b1;
      #20;
    end
    carry = (slot == W) ? (v & 1) : 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #13;
    // R10 reset state
    chk(sclk == 1'b0, "R10 sclk", sclk, 0);
    chk(rclk == 1'b0, "R10 rclk", rclk, 0);
    chk(oe_n == 1'b1, "R10 oe", oe_n, 1);
    chk({sdo_l, sdo_r} == 2'b00, "R10 sdo", {sdo_l, sdo_r}, 0);
    #20 rst_n = 1'b1;
    #50;

    // R9: stray bits, then a right word with no left word before it
    for (int k = 0; k < 5; k++) begin
      ws = 1'b0; sd = 1'b1; bclk = 1'b0; #20; bclk = 1'b1; #20;
    end
    send_word(1'b1, 42, 8);

    // R1: 8-bit slots, trailing bits unused
    for (int i = 0; i < 64; i++) begin
      exp_l[i] = i;
      exp_r[i] = (i * 37 + 11) % 64;
      send_word(1'b0, exp_l[i], 8);
      send_word(1'b1, exp_r[i], 8);
    end
    // R2: slots exactly W wide, LSB on the word-select change
    for (int i = 0; i < 64; i++) begin
      exp_l[64+i] = 63 - i;
      exp_r[64+i] = (i * 21 + 32) % 64;
      send_word(1'b0, exp_l[64+i], W);
      send_word(1'b1, exp_r[64+i], W);
    end
    send_word(1'b0, 0, W);
    send_word(1'b0, 0, W);
    #2000;

    chk(nl == NF, "R9 transfer count", nl, NF);
    for (int i = 0; i < NF && i < nl; i++) begin
      logic [LEN-1:0] el, er;
      el = exp_chain(exp_l[i]);
      er = exp_chain(exp_r[i]);
      // R3 R4 R5 R7 left chain; R1 (first half) R2 (second half)
      chk(lat_l[i] === el, (i < 64) ? "R1 R3 R4 R5 R7 left" : "R2 R3 R4 R5 R7 left", lat_l[i], el);
      chk(lat_r[i] === er, (i < 64) ? "R1 R3 R4 R5 R7 right" : "R2 R3 R4 R5 R7 right", lat_r[i], er);
      chk(sh_at[i] - ((i == 0) ? 0 : sh_at[i-1]) == LEN, "R6 shifts per update",
          sh_at[i] - ((i == 0) ? 0 : sh_at[i-1]), LEN);
      chk(oe_at[i] == ((i == 0) ? 1'b1 : 1'b0), "R8 oe at storage pulse", oe_at[i], (i == 0) ? 1 : 0);
    end
    chk(oe_n == 1'b0, "R8 oe after first update", oe_n, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule